// File: doc/BRIEF.md
# Decrementer Interval Timer

This block is a down-counting tick timer for a processor core. A counter, `WIDTH` bits wide (32 by default), steps down by one on every clock cycle where the timebase tick enable is high. When the count makes a chosen transition, the block latches an interrupt request. That request stays high until the core acknowledges it. Software loads the counter through a single-cycle write port and can read the live count back at any time.

A parameter picks one of two counting behaviours. In the free-running decrementer mode the counter wraps from zero to all-ones and keeps going. A second parameter picks the interrupt transition in that mode: either zero to all-ones, or one to zero. When the zero to all-ones transition is chosen, software loads N-1 to get an interrupt after N ticks. In the interval-timer mode the counter halts at zero, and the interrupt comes on the one-to-zero step. If the auto-reload input is high, the step that would reach zero reloads the value last written instead, which gives a periodic tick.

Top module: `dtm_timer`

## Requirements
- R1: While `rst` is high, on each clock edge the count goes to 0 and `irq` goes to 0; the stored reload value also goes to 0.
- R2: A cycle with `wr_en` high loads `wr_data` into the count at the next edge, and into the reload value in interval mode. It takes priority over a tick in the same cycle, and that cycle raises no interrupt event.
- R3: Without a write, the count changes only on cycles with `tick_en` high; it holds its value on all other cycles.
- R4: In free-running mode each tick subtracts one modulo 2^WIDTH, so a tick at 0 gives all-ones and counting continues from there.
- R5: In free-running mode with the underflow trigger, a tick at count 0 sets `irq` at the same edge that the count wraps. Loading N-1 therefore raises `irq` on the N-th tick, and not before.
- R6: With the one-to-zero trigger (free-running mode), and always in interval mode, a tick at count 1 sets `irq` at that edge. Loading N therefore raises `irq` on the N-th tick, and not before.
- R7: In interval mode with `reload_en` low, the count stops at 0; later ticks leave it at 0 and raise no interrupt.
- R8: In interval mode with `reload_en` high, a tick at count 1 loads the last written value instead of 0, and still raises the interrupt.
- R9: `irq` stays high until a cycle with `irq_ack` high. Such a cycle clears `irq` at the next edge when no new event occurs in that cycle.
- R10: If `irq_ack` and a new interrupt event fall in the same cycle, `irq` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase tick; one decrement per high cycle |
| wr_en | input | 1 | Load strobe for the count |
| wr_data | input | WIDTH | Value to load |
| reload_en | input | 1 | Auto-reload enable (interval mode) |
| irq_ack | input | 1 | Interrupt acknowledge |
| rd_data | output | WIDTH | Current count, registered |
| irq | output | 1 | Sticky interrupt request, registered |

## Verification
The assertions assume that `tick_en`, `wr_en`, `irq_ack` and `reload_en` are synchronous to `clk` and hold no unknown values once reset is released. They also assume that `wr_data` is valid whenever `wr_en` is high. The bench changes every input one time unit after a rising edge, holds it stable through the next edge, and reads outputs at that same offset. Three 8-bit instances, one per mode and trigger, take the same control stimulus with their own write data. This lets the sweeps over load values, full wraps, and tick patterns finish in a few thousand cycles.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
  typedef enum logic {
    DTM_WRAP     = 1'b0,
    DTM_INTERVAL = 1'b1
  } dtm_mode_e;

  typedef enum logic {
    DTM_TRIG_UNDERFLOW   = 1'b0,
    DTM_TRIG_ONE_TO_ZERO = 1'b1
  } dtm_trig_e;
endpackage

// File: rtl/dtm_count.sv
module dtm_count #(
  parameter int WIDTH = 32,
  parameter dtm_pkg::dtm_mode_e MODE = dtm_pkg::DTM_INTERVAL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             reload_en,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_dec;

  generate
    if (MODE == dtm_pkg::DTM_WRAP) begin : g_wrap
      // modulo decrement, all-ones follows zero
      always_comb cnt_dec = cnt_q - ONE;
    end else begin : g_interval
      logic [WIDTH-1:0] reload_q;

      always_ff @(posedge clk) begin
        if (rst)        reload_q <= ZERO;
        else if (wr_en) reload_q <= wr_data;
      end

      always_comb begin
        if (cnt_q == ZERO)                  cnt_dec = ZERO;      // halted
        else if (cnt_q == ONE && reload_en) cnt_dec = reload_q;  // periodic
        else                                cnt_dec = cnt_q - ONE;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= ZERO;
    else if (wr_en)   cnt_q <= wr_data;
    else if (tick_en) cnt_q <= cnt_dec;
  end

  assign count = cnt_q;
endmodule

// File: rtl/dtm_event.sv
module dtm_event #(
  parameter int WIDTH = 32,
  parameter dtm_pkg::dtm_mode_e MODE = dtm_pkg::DTM_INTERVAL,
  parameter dtm_pkg::dtm_trig_e TRIGGER = dtm_pkg::DTM_TRIG_UNDERFLOW
) (
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] count,
  output logic             fire
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  // underflow trigger only exists where the counter can wrap
  localparam bit FROM_ZERO = (MODE == dtm_pkg::DTM_WRAP) &&
                             (TRIGGER == dtm_pkg::DTM_TRIG_UNDERFLOW);

  logic step;
  assign step = tick_en && !wr_en;

  generate
    if (FROM_ZERO) begin : g_underflow
      assign fire = step && (count == '0);
    end else begin : g_one_to_zero
      assign fire = step && (count == ONE);
    end
  endgenerate
endmodule

// File: rtl/dtm_irq.sv
module dtm_irq (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  logic ack,
  output logic irq
);
  logic irq_q;

  // a new event wins over an acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= fire | (irq_q & ~ack);
  end

  assign irq = irq_q;
endmodule

// File: rtl/dtm_timer.sv
module dtm_timer #(
  parameter int WIDTH = 32,
  parameter dtm_pkg::dtm_mode_e MODE = dtm_pkg::DTM_INTERVAL,
  parameter dtm_pkg::dtm_trig_e TRIGGER = dtm_pkg::DTM_TRIG_UNDERFLOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             reload_en,
  input  logic             irq_ack,
  output logic [WIDTH-1:0] rd_data,
  output logic             irq
);
  logic [WIDTH-1:0] count;
  logic             fire;

  dtm_count #(.WIDTH(WIDTH), .MODE(MODE)) u_count (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .reload_en (reload_en),
    .count     (count)
  );

  dtm_event #(.WIDTH(WIDTH), .MODE(MODE), .TRIGGER(TRIGGER)) u_event (
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .count   (count),
    .fire    (fire)
  );

  dtm_irq u_irq (
    .clk  (clk),
    .rst  (rst),
    .fire (fire),
    .ack  (irq_ack),
    .irq  (irq)
  );

  assign rd_data = count;
endmodule

// File: rtl/dtm_timer_sva.sv
module dtm_timer_sva #(
  parameter int WIDTH = 32,
  parameter dtm_pkg::dtm_mode_e MODE = dtm_pkg::DTM_INTERVAL,
  parameter dtm_pkg::dtm_trig_e TRIGGER = dtm_pkg::DTM_TRIG_UNDERFLOW
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic             reload_en,
  input logic             irq_ack,
  input logic [WIDTH-1:0] rd_data,
  input logic             irq
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk) begin
    if (rst_q) begin
      p_reset_state_r1: assert (rd_data == '0 && !irq);
    end
  end

  p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> rd_data == $past(wr_data));

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    (!wr_en && !tick_en) |=> $stable(rd_data));

  p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  generate
    if (MODE == dtm_pkg::DTM_WRAP) begin : g_wrap_chk
      p_dec_wraps_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick_en) |=> rd_data == $past(rd_data) - ONE);

      if (TRIGGER == dtm_pkg::DTM_TRIG_UNDERFLOW) begin : g_uf
        p_underflow_irq_r5: assert property (@(posedge clk) disable iff (rst)
          (!wr_en && tick_en && rd_data == '0) |=> irq);
      end else begin : g_oz
        p_one_to_zero_irq_r6: assert property (@(posedge clk) disable iff (rst)
          (!wr_en && tick_en && rd_data == ONE) |=> irq);
      end
    end else begin : g_int_chk
      logic [WIDTH-1:0] last_wr;
      always_ff @(posedge clk) begin
        if (rst)        last_wr <= '0;
        else if (wr_en) last_wr <= wr_data;
      end

      p_one_to_zero_irq_r6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick_en && rd_data == ONE) |=> irq);

      p_halt_at_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && rd_data == '0) |=> rd_data == '0);

      p_reload_last_r8: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && tick_en && reload_en && rd_data == ONE)
          |=> rd_data == $past(last_wr));
    end
  endgenerate
endmodule

bind dtm_timer dtm_timer_sva #(.WIDTH(WIDTH), .MODE(MODE), .TRIGGER(TRIGGER)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .reload_en (reload_en),
  .irq_ack   (irq_ack),
  .rd_data   (rd_data),
  .irq       (irq)
);

// File: tb/dtm_timer_tb.sv
module dtm_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, wr = 1'b0, ack = 1'b0, rel = 1'b0;
  logic [W-1:0] wd_a = '0, wd_b = '0, wd_c = '0;
  logic [W-1:0] ra, rb, rc;
  logic ia, ib, ic;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // free-running, underflow trigger
  dtm_timer #(.WIDTH(W), .MODE(dtm_pkg::DTM_WRAP), .TRIGGER(dtm_pkg::DTM_TRIG_UNDERFLOW)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick), .wr_en(wr), .wr_data(wd_a),
    .reload_en(rel), .irq_ack(ack), .rd_data(ra), .irq(ia));
  // free-running, one-to-zero trigger
  dtm_timer #(.WIDTH(W), .MODE(dtm_pkg::DTM_WRAP), .TRIGGER(dtm_pkg::DTM_TRIG_ONE_TO_ZERO)) u_dut_oz (
    .clk(clk), .rst(rst), .tick_en(tick), .wr_en(wr), .wr_data(wd_b),
    .reload_en(rel), .irq_ack(ack), .rd_data(rb), .irq(ib));
  // interval timer
  dtm_timer #(.WIDTH(W), .MODE(dtm_pkg::DTM_INTERVAL), .TRIGGER(dtm_pkg::DTM_TRIG_ONE_TO_ZERO)) u_dut_pit (
    .clk(clk), .rst(rst), .tick_en(tick), .wr_en(wr), .wr_data(wd_c),
    .reload_en(rel), .irq_ack(ack), .rd_data(rc), .irq(ic));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic write3(input int a, input int b, input int c);
    wr = 1'b1; wd_a = W'(a); wd_b = W'(b); wd_c = W'(c);
    step();
    wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic ack_all();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int k;
    logic [15:0] pat;
    // R1: reset state
    #1;
    repeat (3) step();
    chk("R1 count a", ra, 0); chk("R1 irq a", ia, 0);
    chk("R1 count c", rc, 0); chk("R1 irq c", ic, 0);
    rst = 1'b0;
    step();

    // R5/R6/R4/R7: interrupt timing sweep over N
    for (int n = 1; n <= 24; n++) begin
      ack_all();
      write3(n - 1, n, n);
      tick = 1'b1;
      repeat (n - 1) step();
      chk("R5 no early irq a", ia, 0);
      chk("R6 no early irq b", ib, 0);
      chk("R6 no early irq c", ic, 0);
      step();
      tick = 1'b0;
      chk("R5 irq after N ticks a", ia, 1);
      chk("R6 irq after N ticks b", ib, 1);
      chk("R6 irq after N ticks c", ic, 1);
      chk("R4 wrap to all-ones a", ra, MOD - 1);
      chk("R6 count zero b", rb, 0);
      chk("R7 count zero c", rc, 0);
      ack_all();
      ticks(3);
      chk("R4 counts on after wrap a", ra, MOD - 4);
      chk("R4 counts on after wrap b", rb, MOD - 3);
      chk("R7 halted at zero c", rc, 0);
      chk("R7 no irq while halted c", ic, 0);
      chk("R5 no irq past wrap a", ia, 0);
      chk("R6 no irq past wrap b", ib, 0);
    end

    // R3: decrement only on tick cycles
    write3(200, 200, 200);
    pat = 16'b1011_0010_0110_1001;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      tick = pat[i];
      if (pat[i]) k++;
      step();
    end
    tick = 1'b0;
    chk("R3 pattern a", ra, 200 - k);
    chk("R3 pattern b", rb, 200 - k);
    chk("R3 pattern c", rc, 200 - k);
    repeat (4) step();
    chk("R3 hold without tick a", ra, 200 - k);
    chk("R3 hold without tick c", rc, 200 - k);

    // R2: write wins over tick, no event in write cycle
    write3(0, 1, 1);
    ack_all();
    tick = 1'b1; wr = 1'b1; wd_a = 8'd50; wd_b = 8'd60; wd_c = 8'd70;
    step();
    tick = 1'b0; wr = 1'b0;
    chk("R2 load a", ra, 50); chk("R2 load b", rb, 60); chk("R2 load c", rc, 70);
    chk("R2 no event a", ia, 0); chk("R2 no event b", ib, 0); chk("R2 no event c", ic, 0);

    // R4: full revolution
    write3(5, 5, 5);
    ack_all();
    ticks(MOD);
    chk("R4 full turn a", ra, 5); chk("R5 irq on turn a", ia, 1);
    chk("R4 full turn b", rb, 5); chk("R6 irq on turn b", ib, 1);

    // R8: auto-reload
    rel = 1'b1;
    write3(9, 9, 4);
    ack_all();
    ticks(4);
    chk("R8 irq c", ic, 1); chk("R8 reloaded c", rc, 4);
    ack_all();
    ticks(4);
    chk("R8 irq second period c", ic, 1); chk("R8 reloaded again c", rc, 4);
    ticks(2);
    chk("R8 counting c", rc, 2);

    // R9: sticky until acknowledged
    repeat (10) step();
    chk("R9 sticky c", ic, 1);
    ack_all();
    chk("R9 cleared by ack c", ic, 0);

    // R10: ack and event in the same cycle
    write3(9, 9, 3);
    ticks(3);
    chk("R10 setup irq c", ic, 1);
    ticks(2);
    chk("R10 count c", rc, 1);
    ack = 1'b1; tick = 1'b1;
    step();
    ack = 1'b0; tick = 1'b0;
    chk("R10 irq kept c", ic, 1);
    chk("R8 reload on event c", rc, 3);
    ack_all();
    chk("R9 clear c", ic, 0);

    // R7: no reload, halt at zero
    rel = 1'b0;
    write3(9, 9, 2);
    ticks(2);
    chk("R7 irq c", ic, 1); chk("R7 zero c", rc, 0);
    ack_all();
    ticks(5);
    chk("R7 stays zero c", rc, 0); chk("R7 no new irq c", ic, 0);

    done = 1;
    summary();
  end
endmodule